// File: doc/BRIEF.md
# Cartridge ROM Block-Transfer Controller

This controller runs on the host side of a cartridge slot. Software writes an eight-byte command and then writes the control word with its start bit set. The block decodes the first command byte. For a data read it fetches the requested block from a byte-wide ROM port and hands it back one 32-bit word at a time through a data port. Words arrive at a pace set by a programmable latency and a byte-time cost. A per-word DMA request and an end-of-block interrupt let a host move the data without polling.

Three commands are handled. A data read takes a 32-bit start address from the command, and an address in the protected low region is redirected. A chip-identification command returns a fixed word at once. Any other code ends immediately with no data. The host owns the flow: every read of the data port consumes the current word and, if bytes remain, starts the fetch of the next one.

Top module: `cart_xfer_ctrl`

## Requirements
- R1: A pulse on `ctl_wr` with `ctl_start` high latches `cmd_bytes` (byte i in bits 8i+7:8i, byte 0 the opcode) and begins that command. A pulse with `ctl_start` low leaves `busy`, `word_ready` and every other output unchanged.
- R2: For opcode 0xB7, the 3-bit `ctl_size` gives the block length. Code 0 means no words: `busy` clears on the start edge and no word arrives. Codes 1 to 6 mean 256 shifted left by the code, in bytes. Code 7 means a single 4-byte word.
- R3: For opcode 0xB7, command bytes 1 to 4 form the start address, byte 1 most significant. Each word is assembled little-endian from `rom_byte` at four consecutive byte addresses, and consecutive words come from consecutive 4-byte addresses.
- R4: A read start address below 0x8000 is replaced by 0x8000 plus the low 9 bits of the requested address.
- R5: The first word of a read reaches `word_ready` (latency + 12) byte-times after the start edge.
- R6: One byte-time is 5 clocks with `ctl_rate` low and 8 clocks with it high. Both values double while `slow_owner` is high.
- R7: A `data_rd` pulse while `word_ready` is high clears `word_ready`. If bytes remain, the next word arrives 4 byte-times later. A `data_rd` while `word_ready` is low is ignored and does not shift the timing.
- R8: A `data_rd` of the last word of a block clears `busy`.
- R9: A one-cycle `irq` pulse accompanies the arrival of the last word of a block when `irq_en` is high, and no pulse appears otherwise.
- R10: While `dma_armed` is high, every arriving word gives a one-cycle `dma_req` pulse. On the last word, `dma_disable` pulses if `dma_repeat` is low.
- R11: Opcode 0xB8 makes `data_out` equal to the chip-ID parameter with `word_ready` and `busy` high on the start edge. Reading that word clears `busy`.
- R12: Any other opcode clears `busy` on the start edge and produces no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_start | input | 1 | Start bit of the control word |
| ctl_size | input | 3 | Block-size code |
| ctl_rate | input | 1 | Slow transfer-rate select |
| ctl_latency | input | LAT_W | Initial latency in byte-times |
| cmd_bytes | input | 64 | Eight command bytes, byte 0 in the low bits |
| irq_en | input | 1 | Completion interrupt enable |
| slow_owner | input | 1 | Secondary requester owns the slot (doubles byte-time) |
| dma_armed | input | 1 | A DMA channel waits on slot timing |
| dma_repeat | input | 1 | That DMA channel repeats |
| data_rd | input | 1 | Data port read strobe |
| data_out | output | 32 | Current data word |
| rom_addr | output | 32 | ROM byte address |
| rom_rd | output | 1 | ROM byte read active |
| rom_byte | input | 8 | ROM byte at rom_addr (combinational) |
| busy | output | 1 | Command in progress |
| word_ready | output | 1 | A word waits in data_out |
| irq | output | 1 | Completion interrupt pulse |
| dma_req | output | 1 | One-word DMA request pulse |
| dma_disable | output | 1 | End-of-block DMA disable pulse |

## Verification
The bench uses the default parameters: a 13-bit latency field, 256-byte block base, byte-times of 5 and 8 clocks, and a 9-bit redirect window. With these values the single-word code and the 512-byte code run a full 128-word block in a few thousand cycles. That covers the first-word latency, the 4-byte-time pacing between words, and the end-of-block interrupt and DMA pulses. Small latency values keep every byte-time combination, including the doubled slow-owner case, within a short run. The larger block codes use the same decoder and are not run at full length.

// File: rtl/cxfer_pkg.sv
package cxfer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_HOLD = 2'd2
    } xstate_e;

    localparam logic [7:0] OP_READ   = 8'hB7;
    localparam logic [7:0] OP_CHIPID = 8'hB8;
endpackage

// File: rtl/xfer_size_dec.sv
module xfer_size_dec #(
    parameter int BLOCK_LOG2  = 8,
    parameter int SHORT_BYTES = 4,
    parameter int CNT_W       = BLOCK_LOG2 + 7
) (
    input  logic [2:0]       size_code,
    output logic [CNT_W-1:0] size_bytes
);
    logic [CNT_W-1:0] tbl [8];

    genvar g;
    generate
        for (g = 0; g < 8; g++) begin : g_tbl
            if (g == 0) begin : g_none
                assign tbl[g] = '0;
            end else if (g == 7) begin : g_short
                assign tbl[g] = CNT_W'(SHORT_BYTES);
            end else begin : g_pow
                assign tbl[g] = CNT_W'(1) << (BLOCK_LOG2 + g);
            end
        end
    endgenerate

    assign size_bytes = tbl[size_code];
endmodule

// File: rtl/xfer_pacer.sv
module xfer_pacer #(
    parameter int LAT_W    = 13,
    parameter int FAST_CLK = 5,
    parameter int SLOW_CLK = 8,
    localparam int BT_W    = $clog2(2 * SLOW_CLK + 1),
    localparam int TIM_W   = LAT_W + 1 + BT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           abort,
    input  logic           rate,
    input  logic           slow_owner,
    input  logic [LAT_W:0] byte_count,
    output logic           done
);
    logic [TIM_W-1:0] cnt_d, cnt_q;
    logic [BT_W-1:0]  byte_time;

    always_comb begin
        byte_time = rate ? BT_W'(SLOW_CLK) : BT_W'(FAST_CLK);
        if (slow_owner) byte_time = byte_time << 1;
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = TIM_W'(byte_count) * TIM_W'(byte_time);
        end else if (abort) begin
            cnt_d = '0;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TIM_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == TIM_W'(1));

    a_r6_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> !done);
endmodule

// File: rtl/rom_word_fetch.sv
module rom_word_fetch #(
    parameter int ADDR_W = 32,
    parameter int WORD_B = 4,
    localparam int IDX_W = $clog2(WORD_B)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   base,
    input  logic [7:0]          rom_byte,
    output logic [ADDR_W-1:0]   rom_addr,
    output logic                rom_rd,
    output logic [8*WORD_B-1:0] word
);
    typedef struct packed {
        logic                active;
        logic [IDX_W-1:0]    idx;
        logic [ADDR_W-1:0]   base;
        logic [8*WORD_B-1:0] word;
    } fetch_t;

    fetch_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (start) begin
            f_d.active = 1'b1;
            f_d.idx    = '0;
            f_d.base   = base;
        end else if (f_q.active) begin
            f_d.word[8*f_q.idx +: 8] = rom_byte;
            f_d.idx = f_q.idx + IDX_W'(1);
            if (f_q.idx == IDX_W'(WORD_B - 1)) f_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign rom_addr = f_q.base + ADDR_W'(f_q.idx);
    assign rom_rd   = f_q.active;
    assign word     = f_q.word;

    a_r3_fetch_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd && rom_addr == f_q.base + ADDR_W'(WORD_B - 1) && !start) |=> !rom_rd);
endmodule

// File: rtl/cart_xfer_ctrl.sv
module cart_xfer_ctrl
    import cxfer_pkg::*;
#(
    parameter int          LAT_W         = 13,
    parameter int          BLOCK_LOG2    = 8,
    parameter int          SHORT_BYTES   = 4,
    parameter int          FAST_CLK      = 5,
    parameter int          SLOW_CLK      = 8,
    parameter int          FIRST_EXTRA   = 12,
    parameter int          REDIRECT_BITS = 9,
    parameter logic [31:0] SECURE_LIMIT  = 32'h0000_8000,
    parameter logic [31:0] CHIP_ID       = 32'h0000_1FC2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_start,
    input  logic [2:0]       ctl_size,
    input  logic             ctl_rate,
    input  logic [LAT_W-1:0] ctl_latency,
    input  logic [63:0]      cmd_bytes,
    input  logic             irq_en,
    input  logic             slow_owner,
    input  logic             dma_armed,
    input  logic             dma_repeat,
    input  logic             data_rd,
    output logic [31:0]      data_out,
    output logic [31:0]      rom_addr,
    output logic             rom_rd,
    input  logic [7:0]       rom_byte,
    output logic             busy,
    output logic             word_ready,
    output logic             irq,
    output logic             dma_req,
    output logic             dma_disable
);
    localparam int CNT_W  = BLOCK_LOG2 + 7;
    localparam int WORD_B = 4;

    typedef struct packed {
        xstate_e          st;
        logic             busy;
        logic             ready;
        logic [31:0]      data;
        logic [CNT_W-1:0] remain;
        logic [31:0]      addr;
        logic             rate;
        logic             irq;
        logic             dmareq;
        logic             dmadis;
    } ctl_t;

    ctl_t s_d, s_q;

    logic [CNT_W-1:0] size_bytes;
    logic             pace_load, pace_abort, pace_done;
    logic [LAT_W:0]   pace_bytes;
    logic             fetch_start;
    logic [31:0]      fetch_base;
    logic [31:0]      fetch_word;
    logic [31:0]      req_addr, start_addr;
    logic             go;

    xfer_size_dec #(.BLOCK_LOG2(BLOCK_LOG2), .SHORT_BYTES(SHORT_BYTES), .CNT_W(CNT_W)) u_size (
        .size_code (ctl_size),
        .size_bytes(size_bytes)
    );

    xfer_pacer #(.LAT_W(LAT_W), .FAST_CLK(FAST_CLK), .SLOW_CLK(SLOW_CLK)) u_pace (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (pace_load),
        .abort     (pace_abort),
        .rate      (s_d.rate),
        .slow_owner(slow_owner),
        .byte_count(pace_bytes),
        .done      (pace_done)
    );

    rom_word_fetch #(.ADDR_W(32), .WORD_B(WORD_B)) u_fetch (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (fetch_start),
        .base    (fetch_base),
        .rom_byte(rom_byte),
        .rom_addr(rom_addr),
        .rom_rd  (rom_rd),
        .word    (fetch_word)
    );

    assign go       = ctl_wr && ctl_start;
    assign req_addr = {cmd_bytes[15:8], cmd_bytes[23:16], cmd_bytes[31:24], cmd_bytes[39:32]};
    assign start_addr = (req_addr < SECURE_LIMIT)
                      ? (SECURE_LIMIT + {{(32-REDIRECT_BITS){1'b0}}, req_addr[REDIRECT_BITS-1:0]})
                      : req_addr;

    always_comb begin
        s_d         = s_q;
        s_d.irq     = 1'b0;
        s_d.dmareq  = 1'b0;
        s_d.dmadis  = 1'b0;
        pace_load   = 1'b0;
        pace_abort  = 1'b0;
        pace_bytes  = '0;
        fetch_start = 1'b0;
        fetch_base  = s_q.addr;

        if (go) begin
            pace_abort = 1'b1;
            s_d.rate   = ctl_rate;
            s_d.ready  = 1'b0;
            unique case (cmd_bytes[7:0])
                OP_READ: begin
                    s_d.addr   = start_addr;
                    s_d.remain = size_bytes;
                    if (size_bytes == '0) begin
                        s_d.busy = 1'b0;
                        s_d.st   = ST_IDLE;
                    end else begin
                        s_d.busy    = 1'b1;
                        s_d.st      = ST_WAIT;
                        pace_load   = 1'b1;
                        pace_bytes  = (LAT_W+1)'(ctl_latency) + (LAT_W+1)'(FIRST_EXTRA);
                        fetch_start = 1'b1;
                        fetch_base  = start_addr;
                    end
                end
                OP_CHIPID: begin
                    s_d.data   = CHIP_ID;
                    s_d.ready  = 1'b1;
                    s_d.busy   = 1'b1;
                    s_d.remain = '0;
                    s_d.st     = ST_HOLD;
                end
                default: begin
                    s_d.busy   = 1'b0;
                    s_d.remain = '0;
                    s_d.st     = ST_IDLE;
                end
            endcase
        end else begin
            unique case (s_q.st)
                ST_WAIT: begin
                    if (pace_done) begin
                        s_d.ready  = 1'b1;
                        s_d.data   = fetch_word;
                        s_d.remain = s_q.remain - CNT_W'(WORD_B);
                        s_d.addr   = s_q.addr + 32'(WORD_B);
                        s_d.dmareq = dma_armed;
                        if (s_q.remain == CNT_W'(WORD_B)) begin
                            s_d.irq    = irq_en;
                            s_d.dmadis = dma_armed && !dma_repeat;
                        end
                        s_d.st = ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (data_rd) begin
                        s_d.ready = 1'b0;
                        if (s_q.remain != '0) begin
                            pace_load   = 1'b1;
                            pace_bytes  = (LAT_W+1)'(WORD_B);
                            fetch_start = 1'b1;
                            s_d.st      = ST_WAIT;
                        end else begin
                            s_d.busy = 1'b0;
                            s_d.st   = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign data_out    = s_q.data;
    assign busy        = s_q.busy;
    assign word_ready  = s_q.ready;
    assign irq         = s_q.irq;
    assign dma_req     = s_q.dmareq;
    assign dma_disable = s_q.dmadis;

    a_r7_ready_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> busy);
    a_r10_dma_with_arrival: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> $rose(word_ready));
    a_r9_irq_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (word_ready && s_q.remain == '0));
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && word_ready && !go) |=> !word_ready);
    a_r3_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ready && !data_rd && !go) |=> (word_ready && $stable(data_out)));
endmodule

// File: tb/tb_cart_xfer_ctrl.sv
module tb_cart_xfer_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] CHIP = 32'h0000_1FC2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0, ctl_start = 1'b0, ctl_rate = 1'b0;
    logic [2:0]  ctl_size = '0;
    logic [12:0] ctl_latency = '0;
    logic [63:0] cmd_bytes = '0;
    logic        irq_en = 1'b0, slow_owner = 1'b0, dma_armed = 1'b0, dma_repeat = 1'b0;
    logic        data_rd = 1'b0;
    logic [31:0] data_out, rom_addr;
    logic        rom_rd, busy, word_ready, irq, dma_req, dma_disable;
    logic [7:0]  rom_byte;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] rb(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction
    function automatic logic [31:0] ew(input logic [31:0] a);
        return {rb(a + 3), rb(a + 2), rb(a + 1), rb(a)};
    endfunction
    function automatic logic [63:0] mkcmd(input logic [7:0] op, input logic [31:0] a);
        return {24'h0, a[7:0], a[15:8], a[23:16], a[31:24], op};
    endfunction
    function automatic int bt(input logic r, input logic s);
        return (r ? 8 : 5) * (s ? 2 : 1);
    endfunction

    assign rom_byte = rb(rom_addr);

    cart_xfer_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_start(ctl_start),
        .ctl_size(ctl_size), .ctl_rate(ctl_rate), .ctl_latency(ctl_latency),
        .cmd_bytes(cmd_bytes), .irq_en(irq_en), .slow_owner(slow_owner),
        .dma_armed(dma_armed), .dma_repeat(dma_repeat), .data_rd(data_rd),
        .data_out(data_out), .rom_addr(rom_addr), .rom_rd(rom_rd), .rom_byte(rom_byte),
        .busy(busy), .word_ready(word_ready), .irq(irq), .dma_req(dma_req),
        .dma_disable(dma_disable)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_ctl(input logic st, input logic [2:0] sz, input logic r,
                             input logic [12:0] lat, input logic [63:0] cmd);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_start = st; ctl_size = sz; ctl_rate = r;
        ctl_latency = lat; cmd_bytes = cmd;
        @(posedge clk);
        #1 ctl_wr = 1'b0; ctl_start = 1'b0;
    endtask

    task automatic wait_word(input int n, input string tag);
        repeat (n - 1) @(posedge clk);
        #1 chk(word_ready == 1'b0, {tag, " early"}, 32'(word_ready), 32'd0);
        @(posedge clk);
        #1 chk(word_ready == 1'b1, {tag, " arrival"}, 32'(word_ready), 32'd1);
    endtask

    task automatic read_word(input logic [31:0] exp, input string tag);
        chk(data_out == exp, {tag, " data"}, data_out, exp);
        data_rd = 1'b1;
        @(posedge clk);
        #1 data_rd = 1'b0;
        chk(word_ready == 1'b0, {tag, " R7 read clears ready"}, 32'(word_ready), 32'd0);
    endtask

    task automatic t_reset();
        chk(busy == 0 && word_ready == 0 && irq == 0 && dma_req == 0 && dma_disable == 0,
            "reset state R1", {27'd0, busy, word_ready, irq, dma_req, dma_disable}, 32'd0);
    endtask

    task automatic t_no_start();
        write_ctl(1'b0, 3'd7, 1'b0, 13'd0, mkcmd(8'hB7, 32'h0001_0000));
        repeat (100) @(posedge clk);
        #1 chk(busy == 0 && word_ready == 0, "R1 write without start ignored",
               {30'd0, busy, word_ready}, 32'd0);
    endtask

    task automatic t_short_read();
        logic [31:0] a = 32'h0001_2340;
        irq_en = 1'b1; slow_owner = 1'b0; dma_armed = 1'b0;
        write_ctl(1'b1, 3'd7, 1'b0, 13'd3, mkcmd(8'hB7, a));
        chk(busy == 1'b1, "R1 busy on start", 32'(busy), 32'd1);
        data_rd = 1'b1;
        @(posedge clk);
        #1 data_rd = 1'b0;
        chk(busy == 1'b1, "R7 early read ignored", 32'(busy), 32'd1);
        wait_word(15 * bt(0, 0) - 1, "R5 R6 fast first word");
        chk(irq == 1'b1, "R9 irq on last word", 32'(irq), 32'd1);
        chk(dma_req == 1'b0, "R10 no dma when unarmed", 32'(dma_req), 32'd0);
        read_word(ew(a), "R3 short read");
        chk(busy == 1'b0, "R8 busy clears after last read", 32'(busy), 32'd0);
    endtask

    task automatic t_slow_doubled();
        logic [31:0] a = 32'h00AB_CD00;
        irq_en = 1'b0; slow_owner = 1'b1;
        write_ctl(1'b1, 3'd7, 1'b1, 13'd0, mkcmd(8'hB7, a));
        wait_word(12 * bt(1, 1), "R6 slow doubled first word");
        chk(irq == 1'b0, "R9 no irq when disabled", 32'(irq), 32'd0);
        read_word(ew(a), "R3 slow read");
        slow_owner = 1'b0;
    endtask

    task automatic t_secure();
        write_ctl(1'b1, 3'd7, 1'b1, 13'd2, mkcmd(8'hB7, 32'h0000_1234));
        wait_word(14 * bt(1, 0), "R4 redirect timing");
        read_word(ew(32'h0000_8034), "R4 secure redirect");
    endtask

    task automatic t_block();
        logic [31:0] a = 32'h0002_0000;
        irq_en = 1'b1; dma_armed = 1'b1; dma_repeat = 1'b0;
        write_ctl(1'b1, 3'd1, 1'b0, 13'd0, mkcmd(8'hB7, a));
        for (int w = 0; w < 128; w++) begin
            wait_word(w == 0 ? 12 * bt(0, 0) : 4 * bt(0, 0), "R2 R7 block word");
            chk(dma_req == 1'b1, "R10 dma per word", 32'(dma_req), 32'd1);
            chk(irq == (w == 127), "R9 irq only on last", 32'(irq), 32'(w == 127));
            chk(dma_disable == (w == 127), "R10 disable only at end", 32'(dma_disable), 32'(w == 127));
            if (w < 127) chk(busy == 1'b1, "R2 busy mid block", 32'(busy), 32'd1);
            read_word(ew(a + 32'(4 * w)), "R3 block");
        end
        chk(busy == 1'b0, "R2 R8 block of 128 words ends", 32'(busy), 32'd0);
        dma_armed = 1'b0;
    endtask

    task automatic t_repeat_dma();
        dma_armed = 1'b1; dma_repeat = 1'b1;
        write_ctl(1'b1, 3'd7, 1'b0, 13'd0, mkcmd(8'hB7, 32'h0003_0010));
        wait_word(12 * bt(0, 0), "R10 repeat word");
        chk(dma_req == 1'b1 && dma_disable == 1'b0, "R10 repeating dma stays enabled",
            {30'd0, dma_req, dma_disable}, 32'd2);
        read_word(ew(32'h0003_0010), "R10 repeat");
        dma_armed = 1'b0; dma_repeat = 1'b0;
    endtask

    task automatic t_size_zero();
        write_ctl(1'b1, 3'd0, 1'b0, 13'd0, mkcmd(8'hB7, 32'h0001_0000));
        chk(busy == 1'b0, "R2 size zero no busy", 32'(busy), 32'd0);
        repeat (100) @(posedge clk);
        #1 chk(word_ready == 1'b0, "R2 size zero no word", 32'(word_ready), 32'd0);
    endtask

    task automatic t_chip_id();
        write_ctl(1'b1, 3'd1, 1'b0, 13'd0, mkcmd(8'hB8, 32'h0));
        chk(word_ready == 1'b1 && busy == 1'b1, "R11 chip id ready at once",
            {30'd0, word_ready, busy}, 32'd3);
        read_word(CHIP, "R11 chip id");
        chk(busy == 1'b0, "R11 busy clears after read", 32'(busy), 32'd0);
    endtask

    task automatic t_other();
        write_ctl(1'b1, 3'd1, 1'b0, 13'd0, mkcmd(8'h9F, 32'h0001_0000));
        chk(busy == 1'b0, "R12 other opcode ends", 32'(busy), 32'd0);
        repeat (200) @(posedge clk);
        #1 chk(word_ready == 1'b0, "R12 other opcode no data", 32'(word_ready), 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_no_start();
        t_short_read();
        t_slow_doubled();
        t_secure();
        t_block();
        t_repeat_dma();
        t_size_zero();
        t_chip_id();
        t_other();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule